// File: doc/BRIEF.md
# Stage-2 Write-Permission Invalidator

This block holds a small fully associative table of cached stage-2 translations for a guest EL1&0 regime. It carries out one kind of maintenance: withdrawing the stage-2 write permission from every cached entry that belongs to a given VMID. The translation itself stays valid. Entries whose VMID differs, and entries that are not valid, are left alone. The ASID and the global flag play no part in the match.

An invalidation request arrives on one of two valid/ready channels. One channel carries requests raised by the local core. The other carries requests broadcast by other cores in the same outer shareable domain. Each request holds a VMID and a variant flag. The plain variant waits for every outstanding access that used a matching entry. The XS-excluding variant waits only for accesses through matching entries whose XS flag is 0. A parameter sets whether the XS-excluding variant also strips write permission from XS=1 entries.

The walker visits one entry per clock. It then drains the outstanding accesses that are in scope, tracked by per-entry in-flight counters, and finally issues a one-cycle done pulse. Back-pressure rules: a requester holds `*_valid` and its fields steady until it sees `*_ready` high at a rising edge. Both ready outputs stay low from acceptance until the done pulse. When both channels request in the same idle cycle, the remote one is taken.

Top module: `tlb_s2w_inval`

## Requirements
- R1: After reset every entry is invalid with write permission 0 and in-flight count 0. The block is idle with `busy`=0 and `inv_done`=0, and both ready outputs are 1.
- R2: A fill (`fill_en`=1 at a rising edge) writes the valid, VMID, ASID, global, XS and write-permission fields of entry `fill_idx`. The result is visible on `valid_map`, `perm_map` and the `lk_*` lookup port. Write permission never rises except through a fill.
- R3: While idle, `rmt_ready`=1, and `loc_ready`=1 only when `rmt_valid`=0. A simultaneous local and remote request therefore accepts the remote one first. While busy, both ready outputs are 0.
- R4: `busy` rises the cycle after acceptance and stays high until the done pulse. With nothing outstanding in scope, `inv_done` is high exactly N+1 cycles after the accepting edge.
- R5: An entry matches when it is valid and its VMID equals the request VMID, whatever its ASID or global flag. A matching entry in clearing scope loses its write permission, while its valid, VMID, ASID and global fields are kept.
- R6: Entries with a different VMID, and invalid entries, keep their write permission and their valid bit.
- R7: With `*_nxs`=1 and parameter XS1_HIT=0 (the default), matching entries whose XS flag is 1 keep their write permission. Matching entries with XS=0 lose it. With XS1_HIT=1, both lose it.
- R8: For a plain request (`*_nxs`=0), `inv_done` is not issued while any matching entry has a nonzero in-flight count.
- R9: For an XS-excluding request (`*_nxs`=1), only matching entries with XS=0 hold back completion. Outstanding accesses on XS=1 entries, or on non-matching entries, do not delay it.
- R10: An entry's in-flight count rises by one on `acc_issue` and falls by one on `acc_retire` for that index. When both arrive in the same cycle for the same entry, the count is unchanged.
- R11: `inv_done` is a single-cycle pulse. `inv_done_rmt` gives the source of the finished request, 1 for remote and 0 for local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one table entry |
| fill_idx | input | IDX_W | Entry to write |
| fill_valid | input | 1 | Valid bit to write |
| fill_vmid | input | VMID_W | VMID to write |
| fill_asid | input | ASID_W | ASID to write |
| fill_global | input | 1 | Global flag to write |
| fill_xs | input | 1 | XS flag to write |
| fill_wperm | input | 1 | Stage-2 write permission to write |
| lk_idx | input | IDX_W | Lookup index |
| lk_asid | output | ASID_W | ASID of entry `lk_idx` |
| lk_global | output | 1 | Global flag of entry `lk_idx` |
| acc_issue | input | 1 | An access through an entry starts |
| acc_issue_idx | input | IDX_W | Entry used by the starting access |
| acc_retire | input | 1 | An access through an entry finishes |
| acc_retire_idx | input | IDX_W | Entry used by the finishing access |
| loc_valid | input | 1 | Local invalidation request valid |
| loc_ready | output | 1 | Local request accepted |
| loc_vmid | input | VMID_W | Local request VMID |
| loc_nxs | input | 1 | Local request is the XS-excluding variant |
| rmt_valid | input | 1 | Broadcast invalidation request valid |
| rmt_ready | output | 1 | Broadcast request accepted |
| rmt_vmid | input | VMID_W | Broadcast request VMID |
| rmt_nxs | input | 1 | Broadcast request is the XS-excluding variant |
| busy | output | 1 | An invalidation is walking or draining |
| inv_done | output | 1 | One-cycle completion pulse |
| inv_done_rmt | output | 1 | Source of the completed request |
| valid_map | output | N | Valid bit of every entry |
| perm_map | output | N | Write permission of every entry |

## Verification
The table is loaded with a mix of entries: matching VMID with XS clear and with XS set, global and non-global, a foreign VMID, an invalid entry with a matching VMID, and a match in the last slot. These entries are invalidated with plain, XS-excluding and no-match requests from both sources. Together these tell VMID matching apart from ASID or global matching, and show that the XS filter is separate from the valid check. A same-cycle local and remote request shows the priority order and the blocking during busy. Drain runs add outstanding accesses on in-scope entries, XS=1 entries and foreign entries, including a simultaneous issue and retire. These separate the plain completion set from the XS-excluding one, and show that counting is exact.

// File: rtl/tlb_s2w_pkg.sv
package tlb_s2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } walk_state_e;
endpackage

// File: rtl/tlb_s2w_arb.sv
module tlb_s2w_arb #(
  parameter int VMID_W = 16
) (
  input  logic              idle,
  input  logic              loc_valid,
  input  logic [VMID_W-1:0] loc_vmid,
  input  logic              loc_nxs,
  input  logic              rmt_valid,
  input  logic [VMID_W-1:0] rmt_vmid,
  input  logic              rmt_nxs,
  output logic              loc_ready,
  output logic              rmt_ready,
  output logic              take,
  output logic              take_rmt,
  output logic [VMID_W-1:0] take_vmid,
  output logic              take_nxs
);
  // Broadcast requests win a tie: remote cores must not be starved by local traffic.
  assign rmt_ready = idle;
  assign loc_ready = idle && !rmt_valid;
  assign take      = idle && (rmt_valid || loc_valid);
  assign take_rmt  = rmt_valid;
  assign take_vmid = rmt_valid ? rmt_vmid : loc_vmid;
  assign take_nxs  = rmt_valid ? rmt_nxs : loc_nxs;
endmodule

// File: rtl/tlb_s2w_table.sv
module tlb_s2w_table #(
  parameter int N      = 16,
  parameter int VMID_W = 16,
  parameter int ASID_W = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_valid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic              fill_xs,
  input  logic              fill_wperm,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [ASID_W-1:0] lk_asid,
  output logic              lk_global,
  input  logic              acc_issue,
  input  logic [IDX_W-1:0]  acc_issue_idx,
  input  logic              acc_retire,
  input  logic [IDX_W-1:0]  acc_retire_idx,
  input  logic [IDX_W-1:0]  walk_idx,
  input  logic              clr_en,
  output logic              rd_valid,
  output logic [VMID_W-1:0] rd_vmid,
  output logic              rd_xs,
  output logic [N-1:0]      cnt_zero,
  output logic [N-1:0]      valid_map,
  output logic [N-1:0]      perm_map
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [VMID_W-1:0] vmid_q [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [N-1:0]      glob_q;
  logic [N-1:0]      xs_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic             fill_hit;
    logic             inc;
    logic             dec;
    logic [CNT_W-1:0] cnt_q;

    assign fill_hit = fill_en && (fill_idx == IDX_W'(i));
    assign inc      = acc_issue  && (acc_issue_idx  == IDX_W'(i));
    assign dec      = acc_retire && (acc_retire_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_map[i] <= 1'b0;
        perm_map[i]  <= 1'b0;
        vmid_q[i]    <= '0;
        asid_q[i]    <= '0;
        glob_q[i]    <= 1'b0;
        xs_q[i]      <= 1'b0;
      end else if (fill_hit) begin
        valid_map[i] <= fill_valid;
        perm_map[i]  <= fill_wperm;
        vmid_q[i]    <= fill_vmid;
        asid_q[i]    <= fill_asid;
        glob_q[i]    <= fill_global;
        xs_q[i]      <= fill_xs;
      end else if (clr_en && (walk_idx == IDX_W'(i))) begin
        perm_map[i]  <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        unique case ({inc, dec})
          2'b10:   cnt_q <= cnt_q + CNT_ONE;
          2'b01:   cnt_q <= (cnt_q == '0) ? cnt_q : cnt_q - CNT_ONE;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    assign cnt_zero[i] = (cnt_q == '0);
  end

  assign rd_valid  = valid_map[walk_idx];
  assign rd_vmid   = vmid_q[walk_idx];
  assign rd_xs     = xs_q[walk_idx];
  assign lk_asid   = asid_q[lk_idx];
  assign lk_global = glob_q[lk_idx];
endmodule

// File: rtl/tlb_s2w_walker.sv
module tlb_s2w_walker
  import tlb_s2w_pkg::*;
#(
  parameter int N       = 16,
  parameter int VMID_W  = 16,
  parameter int IDX_W   = 4,
  parameter bit XS1_HIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_rmt,
  input  logic [VMID_W-1:0] take_vmid,
  input  logic              take_nxs,
  input  logic              rd_valid,
  input  logic [VMID_W-1:0] rd_vmid,
  input  logic              rd_xs,
  input  logic [N-1:0]      cnt_zero,
  output logic [IDX_W-1:0]  walk_idx,
  output logic              clr_en,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic              done_rmt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  walk_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VMID_W-1:0] vmid_q;
  logic              nxs_q;
  logic              rmt_q;
  logic [N-1:0]      scope_q;
  logic              done_q;

  logic hit;
  logic drain_hit;
  logic clr_hit;
  logic drained;

  // ASID and global flag deliberately take no part in the match.
  assign hit       = rd_valid && (rd_vmid == vmid_q);
  assign drain_hit = hit && (!nxs_q || !rd_xs);
  assign clr_hit   = hit && (!nxs_q || !rd_xs || XS1_HIT);
  assign drained   = &(cnt_zero | ~scope_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vmid_q  <= '0;
      nxs_q   <= 1'b0;
      rmt_q   <= 1'b0;
      scope_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            vmid_q  <= take_vmid;
            nxs_q   <= take_nxs;
            rmt_q   <= take_rmt;
            idx_q   <= '0;
            scope_q <= '0;
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          scope_q[idx_q] <= drain_hit;
          if (idx_q == LAST) begin
            state_q <= ST_DRAIN;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_DRAIN: begin
          if (drained) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_idx = idx_q;
  assign clr_en   = (state_q == ST_WALK) && clr_hit;
  assign idle     = (state_q == ST_IDLE);
  assign busy     = !idle;
  assign done     = done_q;
  assign done_rmt = rmt_q;
endmodule

// File: rtl/tlb_s2w_inval.sv
module tlb_s2w_inval #(
  parameter int N       = 16,
  parameter int VMID_W  = 16,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = 4,
  parameter bit XS1_HIT = 1'b0,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_valid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic              fill_xs,
  input  logic              fill_wperm,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [ASID_W-1:0] lk_asid,
  output logic              lk_global,
  input  logic              acc_issue,
  input  logic [IDX_W-1:0]  acc_issue_idx,
  input  logic              acc_retire,
  input  logic [IDX_W-1:0]  acc_retire_idx,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [VMID_W-1:0] loc_vmid,
  input  logic              loc_nxs,
  input  logic              rmt_valid,
  output logic              rmt_ready,
  input  logic [VMID_W-1:0] rmt_vmid,
  input  logic              rmt_nxs,
  output logic              busy,
  output logic              inv_done,
  output logic              inv_done_rmt,
  output logic [N-1:0]      valid_map,
  output logic [N-1:0]      perm_map
);
  logic              idle;
  logic              take;
  logic              take_rmt;
  logic [VMID_W-1:0] take_vmid;
  logic              take_nxs;
  logic [IDX_W-1:0]  walk_idx;
  logic              clr_en;
  logic              rd_valid;
  logic [VMID_W-1:0] rd_vmid;
  logic              rd_xs;
  logic [N-1:0]      cnt_zero;

  tlb_s2w_arb #(.VMID_W(VMID_W)) u_arb (
    .idle      (idle),
    .loc_valid (loc_valid),
    .loc_vmid  (loc_vmid),
    .loc_nxs   (loc_nxs),
    .rmt_valid (rmt_valid),
    .rmt_vmid  (rmt_vmid),
    .rmt_nxs   (rmt_nxs),
    .loc_ready (loc_ready),
    .rmt_ready (rmt_ready),
    .take      (take),
    .take_rmt  (take_rmt),
    .take_vmid (take_vmid),
    .take_nxs  (take_nxs)
  );

  tlb_s2w_table #(
    .N(N), .VMID_W(VMID_W), .ASID_W(ASID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .fill_en        (fill_en),
    .fill_idx       (fill_idx),
    .fill_valid     (fill_valid),
    .fill_vmid      (fill_vmid),
    .fill_asid      (fill_asid),
    .fill_global    (fill_global),
    .fill_xs        (fill_xs),
    .fill_wperm     (fill_wperm),
    .lk_idx         (lk_idx),
    .lk_asid        (lk_asid),
    .lk_global      (lk_global),
    .acc_issue      (acc_issue),
    .acc_issue_idx  (acc_issue_idx),
    .acc_retire     (acc_retire),
    .acc_retire_idx (acc_retire_idx),
    .walk_idx       (walk_idx),
    .clr_en         (clr_en),
    .rd_valid       (rd_valid),
    .rd_vmid        (rd_vmid),
    .rd_xs          (rd_xs),
    .cnt_zero       (cnt_zero),
    .valid_map      (valid_map),
    .perm_map       (perm_map)
  );

  tlb_s2w_walker #(
    .N(N), .VMID_W(VMID_W), .IDX_W(IDX_W), .XS1_HIT(XS1_HIT)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_rmt  (take_rmt),
    .take_vmid (take_vmid),
    .take_nxs  (take_nxs),
    .rd_valid  (rd_valid),
    .rd_vmid   (rd_vmid),
    .rd_xs     (rd_xs),
    .cnt_zero  (cnt_zero),
    .walk_idx  (walk_idx),
    .clr_en    (clr_en),
    .idle      (idle),
    .busy      (busy),
    .done      (inv_done),
    .done_rmt  (inv_done_rmt)
  );
endmodule

// File: rtl/tlb_s2w_chk.sv
module tlb_s2w_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fill_en,
  input logic         loc_valid,
  input logic         loc_ready,
  input logic         rmt_valid,
  input logic         rmt_ready,
  input logic         busy,
  input logic         inv_done,
  input logic [N-1:0] perm_map
);
  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!loc_ready && !rmt_ready));

  a_r3_remote_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rmt_valid) |-> (rmt_ready && !loc_ready));

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_valid && loc_ready) || (rmt_valid && rmt_ready)) |=> busy);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);

  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> (!busy && $past(busy)));

  a_r2_perm_rise_by_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> ((perm_map & ~$past(perm_map)) == '0));
endmodule

bind tlb_s2w_inval tlb_s2w_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fill_en   (fill_en),
  .loc_valid (loc_valid),
  .loc_ready (loc_ready),
  .rmt_valid (rmt_valid),
  .rmt_ready (rmt_ready),
  .busy      (busy),
  .inv_done  (inv_done),
  .perm_map  (perm_map)
);

// File: tb/tlb_s2w_inval_tb_top.sv
`timescale 1ns/1ps
module tlb_s2w_inval_tb_top;
  localparam int N = 16;
  localparam int VW = 16;
  localparam int AW = 8;
  localparam bit XS1 = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_en = 0, fill_valid = 0, fill_global = 0, fill_xs = 0, fill_wperm = 0;
  logic [3:0] fill_idx = '0, lk_idx = '0, acc_issue_idx = '0, acc_retire_idx = '0;
  logic [VW-1:0] fill_vmid = '0, loc_vmid = '0, rmt_vmid = '0;
  logic [AW-1:0] fill_asid = '0, lk_asid;
  logic lk_global, acc_issue = 0, acc_retire = 0;
  logic loc_valid = 0, loc_nxs = 0, rmt_valid = 0, rmt_nxs = 0;
  logic loc_ready, rmt_ready, busy, inv_done, inv_done_rmt;
  logic [N-1:0] valid_map, perm_map;

  always #10 clk = ~clk;

  tlb_s2w_inval #(.N(N), .VMID_W(VW), .ASID_W(AW), .CNT_W(4), .XS1_HIT(XS1)) dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model of table contents
  bit         m_valid [N];
  bit [VW-1:0] m_vmid [N];
  bit         m_xs [N];
  bit [N-1:0] m_perm;

  typedef struct {
    bit         rmt;
    bit [N-1:0] perm;
    bit [N-1:0] vld;
    int         acc;
    int         lmin;
    int         lmax;
  } sb_item_t;
  sb_item_t sb[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [N-1:0] vld_vec();
    bit [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_valid[i];
    return v;
  endfunction

  // Expected write permissions after a request, from R5/R6/R7
  function automatic bit [N-1:0] apply_inv(bit [VW-1:0] vmid, bit nxs);
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_vmid[i] == vmid && (!nxs || !m_xs[i] || XS1))
        m_perm[i] = 1'b0;
    end
    return m_perm;
  endfunction

  task automatic fill(int idx, bit v, int vmid, int asid, bit g, bit xs, bit p);
    @(negedge clk);
    fill_en = 1; fill_idx = 4'(idx); fill_valid = v; fill_vmid = VW'(vmid);
    fill_asid = AW'(asid); fill_global = g; fill_xs = xs; fill_wperm = p;
    @(negedge clk);
    fill_en = 0;
    m_valid[idx] = v; m_vmid[idx] = VW'(vmid); m_xs[idx] = xs; m_perm[idx] = p;
  endtask

  task automatic acc(bit iss, int iidx, bit ret, int ridx);
    @(negedge clk);
    acc_issue = iss; acc_issue_idx = 4'(iidx);
    acc_retire = ret; acc_retire_idx = 4'(ridx);
    @(negedge clk);
    acc_issue = 0; acc_retire = 0;
  endtask

  task automatic send(bit rmt, int vmid, bit nxs, int lmin, int lmax);
    sb_item_t it;
    @(negedge clk);
    if (rmt) begin rmt_valid = 1; rmt_vmid = VW'(vmid); rmt_nxs = nxs; end
    else begin loc_valid = 1; loc_vmid = VW'(vmid); loc_nxs = nxs; end
    forever begin
      #1;
      if ((rmt && rmt_ready) || (!rmt && loc_ready)) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    rmt_valid = 0; loc_valid = 0;
    it.rmt = rmt; it.perm = apply_inv(VW'(vmid), nxs); it.vld = vld_vec();
    it.acc = cyc; it.lmin = lmin; it.lmax = lmax;
    sb.push_back(it);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && inv_done) begin
      if (sb.size() == 0) begin
        chk(0, "R11", "done with no request pending", 1, 0);
      end else begin
        sb_item_t it;
        int lat;
        it = sb.pop_front();
        lat = cyc - it.acc;
        chk(inv_done_rmt == it.rmt, "R11", "done source", inv_done_rmt, it.rmt);
        chk(perm_map == it.perm, "R5/R6/R7", "perm_map", perm_map, it.perm);
        chk(valid_map == it.vld, "R6", "valid_map", valid_map, it.vld);
        chk(lat >= it.lmin && lat <= it.lmax, "R4", "done latency", lat, it.lmin);
      end
      done_cnt++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<200000", cyc);
    finish_run();
  end

  initial begin
    int d0;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_vmid[i] = '0; m_xs[i] = 0; end
    m_perm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(busy == 0 && inv_done == 0, "R1", "idle after reset", {busy, inv_done}, 0);
    chk(valid_map == '0 && perm_map == '0, "R1", "table empty", {valid_map, perm_map}, 0);
    chk(loc_ready && rmt_ready, "R1", "ready when idle", {loc_ready, rmt_ready}, 3);

    // R2 fills: a mixed population
    fill(0, 1, 5, 1, 0, 0, 1);
    fill(1, 1, 5, 2, 1, 1, 1);
    fill(2, 1, 7, 3, 0, 0, 1);
    fill(3, 0, 5, 4, 0, 0, 1);
    fill(4, 1, 5, 9, 1, 0, 1);
    fill(15, 1, 5, 6, 0, 0, 1);
    @(negedge clk); lk_idx = 4; #1;
    chk(valid_map == 16'h8017, "R2", "valid_map after fill", valid_map, 16'h8017);
    chk(perm_map == 16'h801F, "R2", "perm_map after fill", perm_map, 16'h801F);
    chk(lk_asid == 9 && lk_global == 1, "R2", "lookup fields", {lk_asid, lk_global}, {8'd9, 1'b1});

    // R5 R6 R4: plain local request for VMID 5, nothing outstanding
    send(0, 5, 0, N + 1, N + 1);
    wait (sb.size() == 0);
    @(negedge clk); #1;
    chk(lk_asid == 9 && lk_global == 1, "R5", "ASID/global kept", {lk_asid, lk_global}, {8'd9, 1'b1});

    // R7: XS-excluding remote request; refill permissions first
    fill(0, 1, 5, 1, 0, 0, 1);
    fill(1, 1, 5, 2, 1, 1, 1);
    fill(4, 1, 5, 9, 1, 0, 1);
    fill(15, 1, 5, 6, 0, 0, 1);
    send(1, 5, 1, N + 1, N + 1);
    wait (sb.size() == 0);
    @(negedge clk); #1;
    chk(perm_map[1] == 1'b1, "R7", "XS=1 entry keeps permission", perm_map[1], 1);

    // R6: request for a VMID with no entries
    send(0, 9, 0, N + 1, N + 1);
    wait (sb.size() == 0);

    // R3: simultaneous local and remote; remote first, local blocked while busy
    fill(2, 1, 7, 3, 0, 0, 1);
    fill(0, 1, 5, 1, 0, 0, 1);
    @(negedge clk);
    rmt_valid = 1; rmt_vmid = 7; rmt_nxs = 0;
    loc_valid = 1; loc_vmid = 5; loc_nxs = 0;
    #1;
    chk(rmt_ready == 1 && loc_ready == 0, "R3", "remote wins tie", {rmt_ready, loc_ready}, 2);
    @(posedge clk);
    @(negedge clk);
    rmt_valid = 0;
    begin
      sb_item_t it;
      it.rmt = 1; it.perm = apply_inv(7, 0); it.vld = vld_vec();
      it.acc = cyc; it.lmin = N + 1; it.lmax = N + 1;
      sb.push_back(it);
    end
    #1;
    chk(loc_ready == 0 && busy == 1, "R3", "local blocked while busy", {loc_ready, busy}, 1);
    loc_valid = 0;
    send(0, 5, 0, N + 1, 3 * N);
    wait (sb.size() == 0);

    // R8 R10: plain drain
    fill(0, 1, 5, 1, 0, 0, 1);
    fill(1, 1, 5, 2, 1, 1, 1);
    fill(2, 1, 7, 3, 0, 0, 1);
    acc(1, 0, 0, 0);
    acc(1, 0, 0, 0);
    acc(1, 1, 0, 0);
    acc(1, 2, 0, 0);
    d0 = done_cnt;
    send(0, 5, 0, N + 1, 1000);
    repeat (25) @(negedge clk);
    #1;
    chk(done_cnt == d0 && busy, "R8", "waits on outstanding", done_cnt - d0, 0);
    acc(0, 0, 1, 0);
    acc(1, 0, 1, 0);
    repeat (4) @(negedge clk);
    #1;
    chk(done_cnt == d0, "R10", "one access still counted", done_cnt - d0, 0);
    acc(0, 0, 1, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(done_cnt == d0, "R8", "entry 0 still outstanding", done_cnt - d0, 0);
    acc(0, 0, 1, 0);
    @(negedge clk); #1;
    chk(done_cnt == d0 + 1, "R8", "done after last retire", done_cnt - d0, 1);

    // R9: XS-excluding drain; XS=1 and foreign entries do not hold it back
    fill(0, 1, 5, 1, 0, 0, 1);
    fill(1, 1, 5, 2, 1, 1, 1);
    acc(1, 0, 0, 0);
    acc(1, 1, 0, 0);
    d0 = done_cnt;
    send(1, 5, 1, N + 1, 1000);
    repeat (25) @(negedge clk);
    #1;
    chk(done_cnt == d0, "R9", "waits on XS=0 entry", done_cnt - d0, 0);
    acc(0, 0, 1, 0);
    @(negedge clk); #1;
    chk(done_cnt == d0 + 1, "R9", "XS=1 and foreign accesses ignored", done_cnt - d0, 1);
    acc(0, 0, 1, 1);
    acc(0, 0, 1, 2);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R11", "all requests completed", sb.size(), 0);
    finish_run();
  end
endmodule